// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the small register window of a shared-memory communication device that links several processors. Software on the local side uses it to mask and inspect its own interrupt, to learn its own position among the peers, and to ring a doorbell on a remote peer. A doorbell write carries a destination peer number and a vector number. The block checks both against configuration limits and turns a valid request into a one-cycle notify pulse. An outgoing event fabric delivers that pulse.

Incoming events for the local vectors arrive as input pulses. While message-signalled delivery is off, an incoming event loads the value 1 into the status register. A level interrupt output is high whenever status and mask share a set bit. Every access is a 32-bit word on a plain strobe bus. Read data is registered and appears one cycle after the read strobe.

Top module: `doorbell_regs`

## Requirements
- R1: After reset the mask register and the status register both read as zero, and `irq` is low.
- R2: A write to offset 0x0 loads the whole 32-bit word into the mask register. On writes, address bits 1:0 are ignored, so offset 0x3 acts as 0x0 and offset 0xF acts as 0xC. Register read data is returned on `bus_rdata` in the cycle after the read strobe.
- R3: `irq` is high exactly when the bitwise AND of status and mask is nonzero. It takes its new value in the cycle after any write, read or event that changes either register.
- R4: A read of offset 0x4 returns the current status value and clears status to zero at the same clock edge.
- R5: A write to offset 0x4 loads the written word into the status register unchanged.
- R6: A read of offset 0x8 returns `own_id`, zero-extended, while `region_mapped` is high, and 0xFFFFFFFF while it is low.
- R7: Reads of any offset other than 0x0, 0x4 and 0x8 return zero, including the doorbell offset 0xC. Writes to offset 0x8 and to offsets outside 0x0, 0x4 and 0xC change no register.
- R8: A write to offset 0xC decodes bits 31:16 as the destination peer and bits 7:0 as the vector; bits 15:8 are ignored. A valid request raises `notify_valid` for exactly one cycle, in the cycle after the write, with `notify_peer` and `notify_vector` holding the decoded fields.
- R9: A doorbell write is dropped, and `notify_valid` stays low, when the destination is greater than or equal to `cfg_peer_count` or to the peer table size. It is also dropped when the vector is greater than or equal to that peer's count in `cfg_vec_counts`, where peer p uses bits [8p+7:8p].
- R10: With `msi_mode` low, any set bit of `event_in` sets status to exactly 1, discarding earlier bits. With `msi_mode` high, `event_in` leaves status unchanged.
- R11: When an incoming event and a status read fall in the same cycle, the read returns the old status and status becomes 1 afterwards, so the event is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset within the 0x100-byte window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| cfg_peer_count | input | 5 | Number of peers currently known |
| cfg_vec_counts | input | 128 | Per-peer vector counts, 8 bits per peer |
| own_id | input | 16 | This device's peer number |
| region_mapped | input | 1 | Shared region is present |
| msi_mode | input | 1 | High when events are delivered as messages, not through status |
| event_in | input | 4 | Incoming event pulses, one per local vector |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | One-cycle doorbell pulse |
| notify_peer | output | 16 | Destination peer of the pulse |
| notify_vector | output | 8 | Destination vector of the pulse |

## Verification
All three results are due one cycle after the stimulus edge. Read data and the notify pulse are registered, and `irq` follows from registers that update at that same edge. For each access the scoreboard stores its expected item with a due cycle equal to the drive cycle plus one. A second item, due one cycle later, confirms that `notify_valid` has dropped again. The monitor compares items on the falling edge, when the strobes from the previous edge have settled. Each dropped doorbell is checked by expecting `notify_valid` low in the cycle where a valid request would have pulsed.

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PEERS = 16,
  parameter int PEER_W    = 16,
  parameter int VEC_W     = 8,
  parameter int NUM_EVT   = 4,
  localparam int PCNT_W   = $clog2(NUM_PEERS + 1),
  localparam int IDX_W    = $clog2(NUM_PEERS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [31:0]                bus_rdata,
  input  logic [PCNT_W-1:0]          cfg_peer_count,
  input  logic [NUM_PEERS*VEC_W-1:0] cfg_vec_counts,
  input  logic [PEER_W-1:0]          own_id,
  input  logic                       region_mapped,
  input  logic                       msi_mode,
  input  logic [NUM_EVT-1:0]         event_in,
  output logic                       irq,
  output logic                       notify_valid,
  output logic [PEER_W-1:0]          notify_peer,
  output logic [VEC_W-1:0]           notify_vector
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_POS  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_BELL = ADDR_W'(8'h0C);

  logic [31:0] mask_q, status_q;
  logic [ADDR_W-1:0] wr_off;
  logic [PEER_W-1:0] dest;
  logic [VEC_W-1:0]  vec;
  logic [VEC_W-1:0]  vec_cnt [NUM_PEERS];
  logic              dest_ok, bell_ok, evt_hit, stat_rd;

  assign wr_off = {bus_addr[ADDR_W-1:2], 2'b00};
  assign dest   = bus_wdata[31:16];
  assign vec    = bus_wdata[VEC_W-1:0];

  always_comb begin
    for (int p = 0; p < NUM_PEERS; p++)
      vec_cnt[p] = cfg_vec_counts[p*VEC_W +: VEC_W];
  end

  assign dest_ok = (dest < PEER_W'(cfg_peer_count)) && (dest < PEER_W'(NUM_PEERS));
  assign bell_ok = bus_wr && (wr_off == OFF_BELL) && dest_ok &&
                   (vec < vec_cnt[dest[IDX_W-1:0]]);
  assign evt_hit = !msi_mode && (|event_in);
  assign stat_rd = bus_rd && (bus_addr == OFF_STAT);
  assign irq     = |(status_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (bus_wr && wr_off == OFF_MASK) mask_q <= bus_wdata;
      if (evt_hit)                          status_q <= 32'd1;
      else if (stat_rd)                     status_q <= '0;
      else if (bus_wr && wr_off == OFF_STAT) status_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_MASK: bus_rdata <= mask_q;
        OFF_STAT: bus_rdata <= status_q;
        OFF_POS:  bus_rdata <= region_mapped ? 32'(own_id) : 32'hFFFF_FFFF;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify_valid  <= 1'b0;
      notify_peer   <= '0;
      notify_vector <= '0;
    end else begin
      notify_valid <= bell_ok;
      if (bell_ok) begin
        notify_peer   <= dest;
        notify_vector <= vec;
      end
    end
  end
endmodule

module doorbell_regs_chk #(
  parameter int ADDR_W  = 8,
  parameter int PEER_W  = 16,
  parameter int NUM_EVT = 4,
  parameter int PCNT_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [PCNT_W-1:0]  cfg_peer_count,
  input logic               region_mapped,
  input logic               msi_mode,
  input logic [NUM_EVT-1:0] event_in,
  input logic               irq,
  input logic               notify_valid,
  input logic [PEER_W-1:0]  notify_peer,
  input logic [31:0]        status_q
);
  assert_mask_clear_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:2] == '0 && bus_wdata == '0) |=> !irq);

  assert_read_clears_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(4) && (msi_mode || event_in == '0)) |=> status_q == '0);

  assert_unmapped_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8) && !region_mapped) |=> bus_rdata == 32'hFFFF_FFFF);

  assert_notify_from_doorbell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> ($past(bus_wr) && $past(bus_addr[ADDR_W-1:2]) == 3));

  assert_notify_peer_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> notify_peer < PEER_W'($past(cfg_peer_count)));

  assert_event_loads_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_mode && event_in != '0) |=> status_q == 32'd1);
endmodule

bind doorbell_regs doorbell_regs_chk #(
  .ADDR_W(ADDR_W), .PEER_W(PEER_W), .NUM_EVT(NUM_EVT), .PCNT_W(PCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .cfg_peer_count(cfg_peer_count), .region_mapped(region_mapped),
  .msi_mode(msi_mode), .event_in(event_in), .irq(irq),
  .notify_valid(notify_valid), .notify_peer(notify_peer), .status_q(status_q)
);

// File: tb/tb_doorbell_regs.sv
`timescale 1ns/1ps
module tb_doorbell_regs;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_wr = 0, bus_rd = 0;
  logic [31:0]  bus_rdata;
  logic [4:0]   cfg_peer_count = 5'd3;
  logic [127:0] cfg_vec_counts;
  logic [15:0]  own_id = 16'h002A;
  logic         region_mapped = 1;
  logic         msi_mode = 0;
  logic [3:0]   event_in = '0;
  logic         irq, notify_valid;
  logic [15:0]  notify_peer;
  logic [7:0]   notify_vector;

  always #2 clk = ~clk;

  doorbell_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_peer_count(cfg_peer_count), .cfg_vec_counts(cfg_vec_counts),
    .own_id(own_id), .region_mapped(region_mapped), .msi_mode(msi_mode),
    .event_in(event_in), .irq(irq), .notify_valid(notify_valid),
    .notify_peer(notify_peer), .notify_vector(notify_vector));

  localparam int K_RD = 0, K_IRQ = 1, K_NOTE = 2, K_NONE = 3;
  typedef struct { int kind; int req; logic [31:0] val; longint due; } item_t;
  item_t  sb[$];
  longint cyc = 0, drive_cyc = 0;
  int     n_tests = 0, n_fail = 0;
  bit     done = 0;

  always @(posedge clk) cyc++;

  task automatic expect_item(input int kind, input int req, input logic [31:0] val, input int ofs);
    item_t it;
    it.kind = kind; it.req = req; it.val = val; it.due = drive_cyc + 1 + ofs;
    sb.push_back(it);
  endtask

  task automatic fail_line(input int req, input logic [31:0] act, input logic [31:0] exp_v);
    n_fail++;
    $display("FAIL R%0d: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, exp_v, cyc);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      n_tests++;
      case (it.kind)
        K_RD:   act = bus_rdata;
        K_IRQ:  act = {31'd0, irq};
        K_NOTE: act = notify_valid ? {notify_peer, 8'd0, notify_vector} : 32'hDEAD_0000;
        default: act = {31'd0, notify_valid};
      endcase
      if (it.due != cyc || act !== it.val) fail_line(it.req, act, it.val);
    end
  end

  task automatic drive_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; drive_cyc = cyc;
  endtask
  task automatic drive_rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1; drive_cyc = cyc;
  endtask
  task automatic release_bus();
    @(negedge clk); bus_wr = 0; bus_rd = 0; event_in = '0;
  endtask
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    drive_wr(a, d); release_bus();
  endtask
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp_v, input int req);
    drive_rd(a); expect_item(K_RD, req, exp_v, 0); release_bus();
  endtask
  task automatic bell(input logic [7:0] a, input logic [31:0] d, input bit ok, input logic [31:0] exp_v, input int req);
    drive_wr(a, d);
    if (ok) expect_item(K_NOTE, req, exp_v, 0); else expect_item(K_NONE, req, 32'd0, 0);
    expect_item(K_NONE, req, 32'd0, 1);
    release_bus();
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    cfg_vec_counts = '0;
    cfg_vec_counts[7:0]   = 8'd2;
    cfg_vec_counts[15:8]  = 8'd4;
    cfg_vec_counts[23:16] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    drive_rd(8'h00); expect_item(K_RD, 1, 0, 0); expect_item(K_IRQ, 1, 0, 0); release_bus();
    rd_chk(8'h04, 0, 1);

    // R2 mask write and read
    do_wr(8'h00, 32'h5);
    rd_chk(8'h00, 32'h5, 2);

    // R3 / R5 status write raises irq; R4 read clears
    drive_wr(8'h04, 32'h4); expect_item(K_IRQ, 3, 1, 0); release_bus();
    drive_rd(8'h04); expect_item(K_RD, 4, 32'h4, 0); expect_item(K_IRQ, 3, 0, 0); release_bus();
    rd_chk(8'h04, 0, 4);
    drive_wr(8'h04, 32'h2); expect_item(K_IRQ, 3, 0, 0); release_bus();
    rd_chk(8'h04, 32'h2, 5);
    do_wr(8'h04, 32'hA5A5_0F0F);
    rd_chk(8'h04, 32'hA5A5_0F0F, 5);

    // R2 low address bits ignored on writes
    do_wr(8'h03, 32'h7);
    rd_chk(8'h00, 32'h7, 2);

    // R6 position
    rd_chk(8'h08, 32'h2A, 6);
    region_mapped = 0;
    rd_chk(8'h08, 32'hFFFF_FFFF, 6);
    region_mapped = 1;

    // R7 undefined offsets
    rd_chk(8'h10, 0, 7);
    rd_chk(8'h0C, 0, 7);
    rd_chk(8'hFC, 0, 7);
    do_wr(8'h08, 32'h1234);
    rd_chk(8'h08, 32'h2A, 7);
    do_wr(8'h40, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h7, 7);
    rd_chk(8'h04, 0, 7);

    // R8 valid doorbells
    bell(8'h0C, 32'h0001_AB03, 1, {16'd1, 8'd0, 8'd3}, 8);
    bell(8'h0C, 32'h0000_0001, 1, {16'd0, 8'd0, 8'd1}, 8);
    bell(8'h0F, 32'h0001_0000, 1, {16'd1, 8'd0, 8'd0}, 8);

    // R9 dropped doorbells
    bell(8'h0C, 32'h0003_0000, 0, 0, 9);
    bell(8'h0C, 32'h0001_0004, 0, 0, 9);
    bell(8'h0C, 32'h0000_0002, 0, 0, 9);
    bell(8'h0C, 32'h0002_0000, 0, 0, 9);
    bell(8'h0C, 32'h0100_0000, 0, 0, 9);

    // R10 event overwrites status with 1
    do_wr(8'h04, 32'h6);
    @(negedge clk); event_in = 4'b0100; drive_cyc = cyc;
    expect_item(K_IRQ, 10, 1, 0); release_bus();
    rd_chk(8'h04, 32'h1, 10);
    msi_mode = 1;
    do_wr(8'h04, 32'h2);
    @(negedge clk); event_in = 4'b1000; drive_cyc = cyc; release_bus();
    rd_chk(8'h04, 32'h2, 10);
    msi_mode = 0;

    // R11 event beats the clearing read
    do_wr(8'h04, 32'h8);
    drive_rd(8'h04); event_in = 4'b0010; expect_item(K_RD, 11, 32'h8, 0); release_bus();
    rd_chk(8'h04, 32'h1, 11);

    drive_wr(8'h00, 32'h0); expect_item(K_IRQ, 3, 0, 0); release_bus();
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin n_tests++; fail_line(0, sb.size(), 0); end
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R0: watchdog expired, actual 0x%08h expected 0x%08h", 0, 1);
      report();
    end
  end
endmodule